// File: doc/BRIEF.md
# Cluster Membership Recorder

This block sits after the nearest-centroid search in a clustering datapath. For every sample the search presents the index of the winning centroid with a one-cycle strobe, together with the address of that sample in the data store. The recorder turns the index into one update-enable line per cluster. It keeps a running size count for each cluster, and it appends the sample address to a small per-cluster list. Each list uses its own count as the write pointer.

When an assignment pass ends, the counts hold the cluster sizes and each list holds the addresses of its members, in arrival order. The averaging stage reads the lists through a combinational port: it gives a cluster and a slot, and gets back the stored address plus a flag saying whether that slot is occupied. A synchronous clear empties every cluster before the next pass starts. A cluster that already holds as many members as there are samples drops further appends, so its pointer can never run past the end of its list.

Top module: `cluster_member_store`

## Requirements
- R1: After synchronous reset every cluster size reads 0 and every enable line is low.
- R2: While `win_valid` is high, `clr` is low, `win_idx` is below NUM_CLUSTERS and the addressed cluster is not full, exactly bit `win_idx` of `upd_en` is high, in the same cycle. Otherwise no enable bit is high.
- R3: Each accepted strobe raises that cluster's size by exactly one at the next clock edge. The sizes of all other clusters are unchanged. Size k sits in bits [k*CNT_W +: CNT_W] of `size_bus`.
- R4: An accepted strobe stores `samp_addr` into the list of the winning cluster, at the slot equal to that cluster's size before the increment. Earlier entries of every list are kept.
- R5: A cycle with `win_valid` low changes no size and no stored entry.
- R6: A strobe whose `win_idx` is NUM_CLUSTERS or above is ignored: no enable is raised and no size changes.
- R7: A cluster whose size equals NUM_SAMPLES ignores further strobes. Its size stays at NUM_SAMPLES and its enable stays low.
- R8: `clr` high sets every size to 0 at the next edge. A strobe presented in the same cycle is discarded.
- R9: The read port is combinational. When `rd_cluster` is below NUM_CLUSTERS and `rd_slot` is below that cluster's size, `rd_hit` is 1 and `rd_addr` is the stored address. Otherwise `rd_hit` is 0 and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of all cluster sizes between passes |
| win_valid | input | 1 | Strobe marking a valid winning index |
| win_idx | input | IDX_W (2) | Index of the nearest centroid |
| samp_addr | input | ADDR_W (3) | Data-store address of the current sample |
| upd_en | output | NUM_CLUSTERS (3) | Per-cluster update enables, at most one high |
| size_bus | output | NUM_CLUSTERS*CNT_W (12) | Packed cluster sizes |
| rd_cluster | input | IDX_W (2) | Cluster selected for readback |
| rd_slot | input | SLOT_W (3) | Slot within the selected list |
| rd_hit | output | 1 | Selected slot is occupied |
| rd_addr | output | ADDR_W (3) | Address stored in the selected slot, 0 on a miss |

## Verification
The bench drives a long pseudo-random stream of strobes, idle cycles, out-of-range indices and clears. On every clock it compares the enables and sizes against a model that keeps plain integer counts and lists. A design that took the write pointer after the increment would leave slot 0 empty and put the last member one slot past the end. The full readback sweep after each pass would catch it. One cluster is filled to NUM_SAMPLES and then strobed again: a design without saturation would wrap its size to 9 or corrupt slot 0. A strobe that coincides with a clear must leave every size at 0, and a design that gave the append priority would show a size of 1 after the clear.

// File: rtl/cms_pkg.sv
package cms_pkg;

    // Per-lane action chosen by the decoder each cycle
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_APPEND = 2'd2
    } cms_op_e;

    localparam int DEF_CLUSTERS = 3;
    localparam int DEF_SAMPLES  = 8;

    // Bits needed to index n items (at least one)
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Bits needed to hold the value n itself
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cms_decode.sv
module cms_decode
    import cms_pkg::*;
#(
    parameter int NUM_CLUSTERS = DEF_CLUSTERS,
    parameter int IDX_W        = idx_bits(DEF_CLUSTERS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          win_valid,
    input  logic [IDX_W-1:0]              win_idx,
    input  logic [NUM_CLUSTERS-1:0]       lane_full,
    output cms_op_e [NUM_CLUSTERS-1:0]    lane_op,
    output logic [NUM_CLUSTERS-1:0]       lane_en
);

    for (genvar k = 0; k < NUM_CLUSTERS; k++) begin : g_dec
        always_comb begin
            if (clr) begin
                lane_op[k] = OP_CLEAR;
            end else if (win_valid && (win_idx == IDX_W'(k)) && !lane_full[k]) begin
                lane_op[k] = OP_APPEND;
            end else begin
                lane_op[k] = OP_HOLD;
            end
            lane_en[k] = (lane_op[k] == OP_APPEND);
        end
    end

    // R2: never more than one cluster is enabled
    p_onehot_en_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_en));

    // R5: no strobe, no enable
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (lane_en == '0));

    // R6: out-of-range index raises nothing
    p_range_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (win_valid && (int'(win_idx) >= NUM_CLUSTERS)) |-> (lane_en == '0));

    // R8: clear wins over a simultaneous strobe
    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        clr |-> (lane_en == '0));

endmodule

// File: rtl/cms_cluster_lane.sv
module cms_cluster_lane
    import cms_pkg::*;
#(
    parameter int NUM_SAMPLES = DEF_SAMPLES,
    parameter int CNT_W       = cnt_bits(DEF_SAMPLES),
    parameter int SLOT_W      = idx_bits(DEF_SAMPLES),
    parameter int ADDR_W      = idx_bits(DEF_SAMPLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  cms_op_e           op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slots [NUM_SAMPLES];
    logic [SLOT_W-1:0] wr_ptr;
    logic              armed;

    assign full    = (count == CNT_W'(NUM_SAMPLES));
    assign wr_ptr  = count[SLOT_W-1:0];
    assign rd_data = slots[rd_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            unique case (op)
                OP_CLEAR:  count <= '0;
                OP_APPEND: count <= count + CNT_W'(1);
                default:   count <= count;
            endcase
        end
    end

    // List storage: pointer is the pre-increment count
    always_ff @(posedge clk) begin
        if (!rst && (op == OP_APPEND)) begin
            slots[wr_ptr] <= wr_addr;
        end
    end

    // R7: size never exceeds the sample count
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(NUM_SAMPLES));

    // R7: a full lane is never asked to append
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        full |-> (op != OP_APPEND));

    // R3: append steps the size by one
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op) == OP_APPEND) |-> (count == $past(count) + CNT_W'(1)));

    // R5: hold keeps the size
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op) == OP_HOLD) |-> $stable(count));

    // R8: clear empties the lane
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op) == OP_CLEAR) |-> (count == '0));

    // R4: the appended address lands at the old size
    p_slot_write_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op) == OP_APPEND) |-> (slots[$past(wr_ptr)] == $past(wr_addr)));

endmodule

// File: rtl/cms_read_mux.sv
module cms_read_mux
    import cms_pkg::*;
#(
    parameter int NUM_CLUSTERS = DEF_CLUSTERS,
    parameter int IDX_W        = idx_bits(DEF_CLUSTERS),
    parameter int CNT_W        = cnt_bits(DEF_SAMPLES),
    parameter int SLOT_W       = idx_bits(DEF_SAMPLES),
    parameter int ADDR_W       = idx_bits(DEF_SAMPLES)
) (
    input  logic [IDX_W-1:0]                     rd_cluster,
    input  logic [SLOT_W-1:0]                    rd_slot,
    input  logic [NUM_CLUSTERS-1:0][CNT_W-1:0]   lane_count,
    input  logic [NUM_CLUSTERS-1:0][ADDR_W-1:0]  lane_data,
    output logic                                 rd_hit,
    output logic [ADDR_W-1:0]                    rd_addr
);

    always_comb begin
        rd_hit  = 1'b0;
        rd_addr = '0;
        for (int k = 0; k < NUM_CLUSTERS; k++) begin
            if ((rd_cluster == IDX_W'(k)) && (CNT_W'(rd_slot) < lane_count[k])) begin
                rd_hit  = 1'b1;
                rd_addr = lane_data[k];
            end
        end
    end

    // R9: a hit only ever names an existing cluster
    always_comb begin
        if (rd_hit) begin
            a_hit_in_range_r9: assert (int'(rd_cluster) < NUM_CLUSTERS);
        end
    end

endmodule

// File: rtl/cluster_member_store.sv
module cluster_member_store
    import cms_pkg::*;
#(
    parameter int NUM_CLUSTERS = DEF_CLUSTERS,
    parameter int NUM_SAMPLES  = DEF_SAMPLES,
    localparam int IDX_W  = idx_bits(NUM_CLUSTERS),
    localparam int CNT_W  = cnt_bits(NUM_SAMPLES),
    localparam int SLOT_W = idx_bits(NUM_SAMPLES),
    localparam int ADDR_W = idx_bits(NUM_SAMPLES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          win_valid,
    input  logic [IDX_W-1:0]              win_idx,
    input  logic [ADDR_W-1:0]             samp_addr,
    output logic [NUM_CLUSTERS-1:0]       upd_en,
    output logic [NUM_CLUSTERS*CNT_W-1:0] size_bus,
    input  logic [IDX_W-1:0]              rd_cluster,
    input  logic [SLOT_W-1:0]             rd_slot,
    output logic                          rd_hit,
    output logic [ADDR_W-1:0]             rd_addr
);

    cms_op_e [NUM_CLUSTERS-1:0]           lane_op;
    logic    [NUM_CLUSTERS-1:0]           lane_full;
    logic    [NUM_CLUSTERS-1:0][CNT_W-1:0]  lane_count;
    logic    [NUM_CLUSTERS-1:0][ADDR_W-1:0] lane_data;

    cms_decode #(
        .NUM_CLUSTERS(NUM_CLUSTERS),
        .IDX_W       (IDX_W)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .lane_full(lane_full),
        .lane_op  (lane_op),
        .lane_en  (upd_en)
    );

    for (genvar k = 0; k < NUM_CLUSTERS; k++) begin : g_lane
        cms_cluster_lane #(
            .NUM_SAMPLES(NUM_SAMPLES),
            .CNT_W      (CNT_W),
            .SLOT_W     (SLOT_W),
            .ADDR_W     (ADDR_W)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .op     (lane_op[k]),
            .wr_addr(samp_addr),
            .rd_slot(rd_slot),
            .count  (lane_count[k]),
            .full   (lane_full[k]),
            .rd_data(lane_data[k])
        );
        assign size_bus[k*CNT_W +: CNT_W] = lane_count[k];
    end

    cms_read_mux #(
        .NUM_CLUSTERS(NUM_CLUSTERS),
        .IDX_W       (IDX_W),
        .CNT_W       (CNT_W),
        .SLOT_W      (SLOT_W),
        .ADDR_W      (ADDR_W)
    ) u_read (
        .rd_cluster(rd_cluster),
        .rd_slot   (rd_slot),
        .lane_count(lane_count),
        .lane_data (lane_data),
        .rd_hit    (rd_hit),
        .rd_addr   (rd_addr)
    );

    // R3: total size grows by at most one per clock
    p_single_growth_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(upd_en) <= 1));

endmodule

// File: tb/cluster_member_store_test.sv
module cluster_member_store_test;

    localparam int K = 3;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       win_valid = 1'b0;
    logic [1:0] win_idx = '0;
    logic [2:0] samp_addr = '0;
    logic [2:0] upd_en;
    logic [11:0] size_bus;
    logic [1:0] rd_cluster = '0;
    logic [2:0] rd_slot = '0;
    logic       rd_hit;
    logic [2:0] rd_addr;

    int checks = 0;
    int fails  = 0;
    int ref_cnt [K];
    int ref_mem [K][N];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    cluster_member_store uut (
        .clk(clk), .rst(rst), .clr(clr),
        .win_valid(win_valid), .win_idx(win_idx), .samp_addr(samp_addr),
        .upd_en(upd_en), .size_bus(size_bus),
        .rd_cluster(rd_cluster), .rd_slot(rd_slot),
        .rd_hit(rd_hit), .rd_addr(rd_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_sizes(input string req);
        for (int k = 0; k < K; k++) begin
            int act;
            act = int'(size_bus[k*4 +: 4]);
            chk(act == ref_cnt[k], req, act, ref_cnt[k]);
        end
    endtask

    // One clock: drive, check enables, clock, update model, check sizes
    task automatic step(input bit c, input bit v, input int i, input int a, input string req);
        int exp_en;
        clr = c; win_valid = v; win_idx = 2'(i); samp_addr = 3'(a);
        #1;
        exp_en = 0;
        if (!c && v && i < K) begin
            if (ref_cnt[i] < N) exp_en = 1 << i;
        end
        chk(int'(upd_en) == exp_en, req, int'(upd_en), exp_en);
        @(posedge clk);
        if (c) begin
            for (int k = 0; k < K; k++) ref_cnt[k] = 0;
        end else if (exp_en != 0) begin
            ref_mem[i][ref_cnt[i]] = a;
            ref_cnt[i]++;
        end
        @(negedge clk);
        clr = 1'b0; win_valid = 1'b0;
        chk_sizes(req);
    endtask

    // R9: sweep every cluster/slot including out-of-range cluster 3
    task automatic readback();
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < N; s++) begin
                bit exp_hit;
                int exp_a;
                rd_cluster = 2'(k); rd_slot = 3'(s);
                #1;
                exp_hit = (k < K) && (s < ref_cnt[k]);
                exp_a   = exp_hit ? ref_mem[k][s] : 0;
                chk(rd_hit == exp_hit, "R9 hit", int'(rd_hit), int'(exp_hit));
                chk(int'(rd_addr) == exp_a, "R4/R9 addr", int'(rd_addr), exp_a);
            end
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < K; k++) ref_cnt[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk_sizes("R1");
        chk(upd_en == 3'b000, "R1 en", int'(upd_en), 0);

        // R3/R4: directed pass, one sample per cluster in turn
        for (int s = 0; s < N; s++) step(0, 1, s % K, s, "R2/R3");
        readback();

        // R5: idle cycles with changing index and address
        for (int s = 0; s < 4; s++) step(0, 0, s % K, 7 - s, "R5");
        readback();

        // R6: out-of-range index
        step(0, 1, 3, 5, "R6");
        step(0, 1, 3, 2, "R6");

        // R8: clear with simultaneous strobe
        step(1, 1, 0, 6, "R8");
        readback();

        // R7: fill cluster 2 to N, then overflow attempts
        for (int s = 0; s < N; s++) step(0, 1, 2, N - 1 - s, "R7 fill");
        step(0, 1, 2, 1, "R7");
        step(0, 1, 2, 3, "R7");
        step(0, 1, 0, 4, "R7 other");
        readback();
        step(1, 0, 0, 0, "R8");

        // Randomised passes
        for (int p = 0; p < 40; p++) begin
            for (int c = 0; c < 14; c++) begin
                int r;
                r = rnd();
                step(0, (r & 3) != 0, (r >> 2) & 3, (r >> 4) & 7, "R2/R3/R4/R5/R6");
            end
            readback();
            step(1, (p & 1) == 1, p % K, p & 7, "R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule